// File: doc/BRIEF.md
# SDRAM Write-Burst Termination Sequencer

This block drives the command bus, the data bus and the byte mask of a single-data-rate SDRAM from the controller side. It starts four-word write bursts. It also decides how a running burst ends when another request arrives before the burst is finished. The request can be a fresh write, a read or a precharge. Each kind of cut follows its own rule.

- A new write takes over the data bus at once.
- A read releases the bus on its own command cycle, so the bus is free well before the read data returns.
- A precharge to the bank being written masks the dropped words. The block then holds the precharge back until the write-recovery time has passed after the last word that was kept.

A requester presents one request at a time with a valid/ready pair: a kind code, a bank, a row or column, and the four data words for a write. The command goes out on the cycle after the request is accepted. Per-bank counters track two timings:

- write recovery, measured from the last kept word;
- precharge-to-activate time, measured from each precharge.

A separate counter keeps a write off the bus while data from an earlier read may still be returning. Its length depends on the configured CAS latency, which is 2 or 3 clocks.

Top module: `wr_term_seq`

## Requirements
- R1: After reset, `cmd_o` shows NOP (code 0), `dq_oe` and `dqm_o` are low, and `req_ready` is high.
- R2: `cmd_o` shows NOP on every cycle that carries no other command. The output codes are 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE.
- R3: A write request (`req_cmd` 0) accepted at edge e shows WRITE on `cmd_o` from edge e, with word 0 (`req_wdata` bits [DW-1:0]) on `dq_o` in the same cycle. Words 1 to 3 (word i at bits [i*DW +: DW]) follow in the next three cycles with `dq_oe` high.
- R4: A write accepted while a burst is running replaces it. The new WRITE cycle carries the new word 0, and no remaining word of the old burst is driven. This may happen as soon as one clock after the previous WRITE.
- R5: A read request (`req_cmd` 1) accepted while a burst is running shows READ with `dq_oe` low in that same cycle. No later word of the cut burst is driven.
- R6: After a READ shown at edge r, a write is not accepted before edge r + CL + 4 (`req_ready` low for a write request), for CL 2 and 3.
- R7: A precharge request (`req_cmd` 2) to the bank of a running burst stops the data from the cycle it is accepted in. The PRECHARGE command then appears exactly TWR cycles after the cycle of the last kept word.
- R8: During a precharge-cut burst, `dqm_o` is high from the cycle after the last kept word through the PRECHARGE cycle. At all other times it is low.
- R9: A precharge after a completed burst to that bank appears no earlier than TWR cycles after the burst's last word, and `dqm_o` stays low throughout.
- R10: No request (including activate, `req_cmd` 3) to a bank is accepted before TRP cycles after that bank's PRECHARGE.
- R11: A precharge to a bank other than the one being written does not disturb the running burst.
- R12: `req_ready` is low while an accepted precharge waits for write recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat | input | 2 | CAS latency in clocks, 2 or 3 |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | Request kind: 0 write, 1 read, 2 precharge, 3 activate |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row for activate |
| req_col | input | COL_W | Column for read or write |
| req_wdata | input | BL*DW | Four write words, word 0 in the low bits |
| req_ready | output | 1 | Request accepted on this edge when valid |
| cmd_o | output | 3 | Registered bus command code |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row or column of the command |
| dq_o | output | DW | Write data |
| dq_oe | output | 1 | Data output enable |
| dqm_o | output | 1 | Data mask |

## Verification
The bench runs at both CAS latencies with several patterns:

- a burst that runs to its end;
- back-to-back writes one clock apart;
- a write cut by a read and followed at once by a write;
- precharges to the same bank cut after one and after two words;
- a precharge to a different bank during a burst.

A full burst against a cut one tells the final-word handling apart from the truncation path. The two precharge cut points separate the write-recovery wait from the mask window. The other-bank precharge shows that a cut is tied to the bank. Follow-on activates and writes probe the precharge-to-activate wait and the read turnaround wait through `req_ready`.

// File: rtl/wts_pkg.sv
package wts_pkg;
  typedef enum logic [1:0] {
    RQ_WRITE = 2'd0,
    RQ_READ  = 2'd1,
    RQ_PRE   = 2'd2,
    RQ_ACT   = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/wts_bank_timer.sv
// Per-bank countdowns: write recovery and precharge-to-activate.
module wts_bank_timer #(
  parameter int TWR = 2,
  parameter int TRP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_load,
  input  logic rp_load,
  output logic wr_clear,
  output logic rp_clear
);
  localparam int MAXC = (TWR > TRP) ? TWR : TRP;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] wr_cnt;
  logic [CW-1:0] rp_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
      rp_cnt <= '0;
    end else begin
      if (wr_load)           wr_cnt <= CW'(TWR - 1);
      else if (wr_cnt != '0) wr_cnt <= wr_cnt - 1'b1;
      if (rp_load)           rp_cnt <= CW'(TRP - 1);
      else if (rp_cnt != '0) rp_cnt <= rp_cnt - 1'b1;
    end
  end

  assign wr_clear = (wr_cnt == '0);
  assign rp_clear = (rp_cnt == '0);
endmodule

// File: rtl/wts_burst_path.sv
// Write data path: shifts out burst words, stops on a cut or a restart.
module wts_burst_path #(
  parameter int DW     = 32,
  parameter int BL     = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cut,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [BL*DW-1:0]  start_data,
  output logic              busy,
  output logic [BANK_W-1:0] burst_bank,
  output logic              drive_now,
  output logic [BANK_W-1:0] drive_bank,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe
);
  localparam int LW = $clog2(BL + 1);

  logic [LW-1:0]    left_q;
  logic [BL*DW-1:0] data_q;
  logic             continuing;

  assign busy       = (left_q != '0);
  assign burst_bank = bank_q;
  assign continuing = busy && !cut;
  assign drive_now  = start || continuing;
  assign drive_bank = start ? start_bank : bank_q;

  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      data_q <= '0;
      bank_q <= '0;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
    end else if (start) begin
      dq_o   <= start_data[DW-1:0];
      data_q <= start_data >> DW;
      left_q <= LW'(BL - 1);
      bank_q <= start_bank;
      dq_oe  <= 1'b1;
    end else if (continuing) begin
      dq_o   <= data_q[DW-1:0];
      data_q <= data_q >> DW;
      left_q <= left_q - 1'b1;
      dq_oe  <= 1'b1;
    end else begin
      left_q <= '0;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
    end
  end
endmodule

// File: rtl/wr_term_seq.sv
module wr_term_seq
  import wts_pkg::*;
#(
  parameter  int BANKS  = 4,
  parameter  int ROW_W  = 11,
  parameter  int COL_W  = 8,
  parameter  int DW     = 32,
  parameter  int BL     = 4,
  parameter  int TWR    = 2,
  parameter  int TRP    = 3,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cas_lat,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BL*DW-1:0]  req_wdata,
  output logic              req_ready,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe,
  output logic              dqm_o
);
  req_kind_e kind;
  assign kind = req_kind_e'(req_cmd);

  logic [BANKS-1:0]  wr_clear, rp_clear, wr_load, rp_load;
  logic              pend_q, mask_q;
  logic [BANK_W-1:0] pend_bank_q;
  logic [2:0]        rd_cnt;
  logic              busy, drive_now;
  logic [BANK_W-1:0] burst_bank, drive_bank;

  logic acc, wr_go, rd_go, pre_acc, act_go, pre_cut, cut, pre_want, pre_go;
  logic [BANK_W-1:0] pt_bank;

  assign req_ready = !pend_q && rp_clear[req_bank] && !(kind == RQ_WRITE && rd_cnt != 3'd0);
  assign acc      = req_valid && req_ready;
  assign wr_go    = acc && (kind == RQ_WRITE);
  assign rd_go    = acc && (kind == RQ_READ);
  assign pre_acc  = acc && (kind == RQ_PRE);
  assign act_go   = acc && (kind == RQ_ACT);
  assign pre_cut  = pre_acc && busy && (burst_bank == req_bank);
  assign cut      = rd_go || pre_cut;
  assign pt_bank  = pend_q ? pend_bank_q : req_bank;
  assign pre_want = pend_q || pre_acc;
  assign pre_go   = pre_want && wr_clear[pt_bank];

  wts_burst_path #(.DW(DW), .BL(BL), .BANK_W(BANK_W)) u_path (
    .clk(clk), .rst(rst), .start(wr_go), .cut(cut),
    .start_bank(req_bank), .start_data(req_wdata),
    .busy(busy), .burst_bank(burst_bank),
    .drive_now(drive_now), .drive_bank(drive_bank),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign wr_load[b] = drive_now && (drive_bank == BANK_W'(b));
    assign rp_load[b] = pre_go && (pt_bank == BANK_W'(b));
    wts_bank_timer #(.TWR(TWR), .TRP(TRP)) u_tmr (
      .clk(clk), .rst(rst),
      .wr_load(wr_load[b]), .rp_load(rp_load[b]),
      .wr_clear(wr_clear[b]), .rp_clear(rp_clear[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o       <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_addr    <= '0;
      dqm_o       <= 1'b0;
      pend_q      <= 1'b0;
      pend_bank_q <= '0;
      mask_q      <= 1'b0;
      rd_cnt      <= 3'd0;
    end else begin
      pend_q      <= pre_want && !pre_go;
      pend_bank_q <= pt_bank;
      mask_q      <= (pre_cut || mask_q) && !pre_go;
      dqm_o       <= pre_cut || mask_q;

      if (rd_go)               rd_cnt <= {1'b0, cas_lat} + 3'd3;
      else if (rd_cnt != 3'd0) rd_cnt <= rd_cnt - 3'd1;

      if (pre_go) begin
        cmd_o    <= CMD_PRE;
        cmd_bank <= pt_bank;
        cmd_addr <= '0;
      end else if (wr_go) begin
        cmd_o    <= CMD_WRITE;
        cmd_bank <= req_bank;
        cmd_addr <= ADDR_W'(req_col);
      end else if (rd_go) begin
        cmd_o    <= CMD_READ;
        cmd_bank <= req_bank;
        cmd_addr <= ADDR_W'(req_col);
      end else if (act_go) begin
        cmd_o    <= CMD_ACT;
        cmd_bank <= req_bank;
        cmd_addr <= ADDR_W'(req_row);
      end else begin
        cmd_o <= CMD_NOP;
      end
    end
  end
endmodule

// File: rtl/wts_checker.sv
module wts_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd_o,
  input logic       dq_oe,
  input logic       dqm_o
);
  import wts_pkg::*;

  // R3: a data word without a WRITE command only continues a driven burst
  a_r3_data_follows_burst: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != CMD_WRITE && dq_oe) |-> $past(dq_oe));

  // R5: the read command cycle never drives data
  a_r5_read_releases_bus: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_READ) |-> !dq_oe);

  // R6: no write directly behind a read
  a_r6_no_write_after_read: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_READ) |=> (cmd_o != CMD_WRITE));

  // R8: mask is never raised over driven data
  a_r8_mask_no_drive: assert property (@(posedge clk) disable iff (rst)
    dqm_o |-> !dq_oe);

  // R8: mask window closes right after the precharge
  a_r8_mask_ends_at_pre: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_PRE && dqm_o) |=> !dqm_o);

  // R7: mask persists until the precharge is issued
  a_r7_mask_until_pre: assert property (@(posedge clk) disable iff (rst)
    (dqm_o && cmd_o != CMD_PRE) |=> dqm_o);
endmodule

bind wr_term_seq wts_checker u_chk (
  .clk(clk), .rst(rst), .cmd_o(cmd_o), .dq_oe(dq_oe), .dqm_o(dqm_o)
);

// File: tb/wr_term_seq_bench.sv
`timescale 1ns/100ps
module wr_term_seq_bench;
  localparam int TWR = 2;
  localparam int TRP = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   cas_lat = 2'd2;
  logic         req_valid = 1'b0;
  logic [1:0]   req_cmd = 2'd0;
  logic [1:0]   req_bank = 2'd0;
  logic [10:0]  req_row = '0;
  logic [7:0]   req_col = '0;
  logic [127:0] req_wdata = '0;
  logic         req_ready;
  logic [2:0]   cmd_o;
  logic [1:0]   cmd_bank;
  logic [10:0]  cmd_addr;
  logic [31:0]  dq_o;
  logic         dq_oe, dqm_o;

  always #2.5 clk = ~clk;

  wr_term_seq #(.TWR(TWR), .TRP(TRP)) u_wr_term_seq (
    .clk(clk), .rst(rst), .cas_lat(cas_lat), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_wdata(req_wdata), .req_ready(req_ready),
    .cmd_o(cmd_o), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .dq_o(dq_o), .dq_oe(dq_oe), .dqm_o(dqm_o)
  );

  int    nchk = 0;
  int    nfail = 0;
  string cur_tag = "R3";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: timestamps of events and a queue of pending words
  int         cyc = 0;
  logic [31:0] wq[$];
  int         wbank = 0;
  int         last_drive[4];
  int         pre_cyc[4];
  int         last_rd = -1000;
  bit         pend = 0;
  int         pend_bank = 0;
  bit         mask = 0;
  int         e_cmd = 0, e_bank = 0, e_oe = 0, e_dqm = 0;
  logic [31:0] e_dq = '0;

  function automatic bit m_ready();
    int t;
    t = cyc + 1;
    return !pend && (t - pre_cyc[req_bank] >= TRP)
           && !(req_cmd == 2'd0 && (t - last_rd) < int'(cas_lat) + 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; wq.delete(); pend = 0; mask = 0; last_rd = -1000;
      for (int b = 0; b < 4; b++) begin last_drive[b] = -1000; pre_cyc[b] = -1000; end
      e_cmd = 0; e_oe = 0; e_dqm = 0; e_dq = '0;
    end else begin
      int  t;
      bit  acc;
      t   = cyc + 1;
      acc = req_valid && m_ready();
      e_cmd = 0; e_oe = 0; e_dq = '0;
      if (acc) begin
        case (req_cmd)
          2'd0: begin
            wq.delete();
            for (int i = 0; i < 4; i++) wq.push_back(req_wdata[i*32 +: 32]);
            wbank = req_bank; e_cmd = 3; e_bank = req_bank;
          end
          2'd1: begin wq.delete(); e_cmd = 2; e_bank = req_bank; last_rd = t; end
          2'd3: begin e_cmd = 1; e_bank = req_bank; end
          default: begin
            if (wq.size() > 0 && wbank == int'(req_bank)) begin wq.delete(); mask = 1; end
            pend = 1; pend_bank = req_bank;
          end
        endcase
      end
      if (wq.size() > 0) begin
        e_dq = wq.pop_front(); e_oe = 1; last_drive[wbank] = t;
      end
      e_dqm = mask;
      if (pend && (t - last_drive[pend_bank]) >= TWR) begin
        e_cmd = 4; e_bank = pend_bank; pre_cyc[pend_bank] = t; pend = 0; mask = 0;
      end
      cyc = t;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      string rtag;
      chk((e_cmd == 0) ? "R2" : cur_tag, "cmd", int'(cmd_o), e_cmd);
      if (e_cmd != 0) chk(cur_tag, "cmd_bank", int'(cmd_bank), e_bank);
      chk(cur_tag, "dq_oe", int'(dq_oe), e_oe);
      if (e_oe != 0) chk(cur_tag, "dq", int'(dq_o), int'(e_dq));
      chk("R8", "dqm", int'(dqm_o), e_dqm);
      if (pend)                 rtag = "R12";
      else if (req_cmd == 2'd3) rtag = "R10";
      else if (req_cmd == 2'd0) rtag = "R6";
      else                      rtag = cur_tag;
      chk(rtag, "ready", int'(req_ready), int'(m_ready()));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue(input int kind, input int bank, input int base);
    bit r;
    req_valid = 1'b1;
    req_cmd   = 2'(kind);
    req_bank  = 2'(bank);
    req_row   = 11'(bank * 100 + 7);
    req_col   = 8'(bank * 3 + 1);
    req_wdata = {32'(base + 3), 32'(base + 2), 32'(base + 1), 32'(base)};
    forever begin
      @(negedge clk);
      r = req_ready;
      @(posedge clk);
      #1;
      if (r) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset cmd", int'(cmd_o), 0);
    chk("R1", "reset dq_oe", int'(dq_oe), 0);
    chk("R1", "reset dqm", int'(dqm_o), 0);
    chk("R1", "reset ready", int'(req_ready), 1);
    @(posedge clk); #1;

    for (int cl = 2; cl <= 3; cl++) begin
      cas_lat = 2'(cl);
      idle(2);
      cur_tag = "R3";  issue(0, 0, 32'h100 * cl);        idle(6);
      cur_tag = "R9";  issue(0, 3, 32'h200 * cl);        idle(3);
      issue(2, 3, 0);
      cur_tag = "R10"; issue(3, 3, 0);                    idle(6);
      cur_tag = "R4";  issue(0, 1, 32'h300 * cl);
      issue(0, 2, 32'h400 * cl);                          idle(8);
      cur_tag = "R5";  issue(0, 0, 32'h500 * cl);
      issue(1, 2, 0);
      cur_tag = "R6";  issue(0, 1, 32'h600 * cl);         idle(8);
      cur_tag = "R7";  issue(0, 1, 32'h700 * cl);         idle(1);
      issue(2, 1, 0);
      cur_tag = "R10"; issue(3, 1, 0);                    idle(8);
      cur_tag = "R7";  issue(0, 0, 32'h800 * cl);
      issue(2, 0, 0);                                     idle(8);
      cur_tag = "R11"; issue(0, 2, 32'h900 * cl);
      issue(2, 0, 0);                                     idle(8);
    end

    summary();
    $finish;
  end
endmodule